// File: doc/BRIEF.md
# Switch Event Capture and Interrupt Register

This block sits between a switch core and a host processor. The switch core reports events as single-cycle pulses: one link event line per port, a PHY event, a time-sync event and three sleep-timer expiries. Each pulse is latched into a sticky bit of a 32-bit capture word. The bit stays set until the host clears it by writing a one to that bit position.

A second 32-bit word holds a single global delivery-enable bit. Each captured bit drives its own level interrupt line, and one combined host interrupt is also produced. All of these lines are masked by the delivery-enable bit. Capture itself runs whether delivery is enabled or not, so the host can poll the word with delivery off and see pending events.

The host side is a plain register slave. It has a one-cycle write strobe with address and data, and a read data bus that always shows the word at the current address. One port position in the capture word is permanently absent and never sets.

Top module: `evt_capture_top`

## Requirements
- R1: After reset, the capture word and the delivery-enable bit are zero, and every interrupt output is low.
- R2: A one-cycle pulse on `port_evt[n]` sets capture bit n from the next clock edge on, for n in 0..5 and n = 7. The bit stays set after the pulse ends.
- R3: A pulse on `phy_evt` sets capture bit 8, and a pulse on `tsync_evt` sets capture bit 9.
- R4: Pulses on `sleep_evt[0]`, `sleep_evt[1]` and `sleep_evt[2]` set capture bits 10, 11 and 12. These are the first management port, port 7 and the second management port.
- R5: A write to offset 0x44 clears every capture bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears all pending bits.
- R6: If a new pulse and a clearing write hit the same capture bit in the same cycle, the bit is set after that edge.
- R7: Capture bit 6 is never set, whatever arrives on `port_evt[6]`, and it always reads 0.
- R8: Capture word bits 31:13 read 0 and ignore writes. In the control word at offset 0x40, only bit 1 is stored; all other bits read 0.
- R9: Bit 1 of the control word enables delivery. `src_irq[i]` is high exactly when capture bit i is set and delivery is enabled. With delivery off, all interrupt outputs are low while capture continues.
- R10: `host_irq` is high exactly when at least one bit of `src_irq` is high.
- R11: A read of any offset other than 0x40 or 0x44 returns 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_evt | input | 8 | Per-port link event pulses |
| phy_evt | input | 1 | Switch PHY event pulse |
| tsync_evt | input | 1 | Time-sync event pulse |
| sleep_evt | input | 3 | Sleep-timer pulses: mgmt port 0, port 7, mgmt port 1 |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at reg_addr |
| src_irq | output | 13 | Per-source level interrupts |
| host_irq | output | 1 | Combined host interrupt |

## Verification
The hardest case to reach is a clearing write landing in the same cycle as a fresh pulse on the same bit. Close to it are writes that mix ones and zeros over a word that already holds events. The stimulus creates both on purpose: it fires a pulse while writing the clear mask for that very bit, and it also clears only part of a populated word. A long random phase then overlaps sparse pulses on every source with random clear masks and random toggling of the enable bit. Every cycle is checked against a behavioural model.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;
    localparam int unsigned CTRL_OFFSET  = 32'h40;
    localparam int unsigned CAPT_OFFSET  = 32'h44;
    localparam int unsigned ENABLE_BIT   = 1;
    localparam int unsigned SLEEP_LINES  = 3;
    localparam int unsigned MISC_LINES   = 2;
    localparam int unsigned EXTRA_LINES  = MISC_LINES + SLEEP_LINES;
endpackage

// File: rtl/evt_pulse_merge.sv
module evt_pulse_merge
    import evt_capture_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 8,
    parameter int unsigned ABSENT_PORT = 6,
    localparam int unsigned CAP_W      = NUM_PORTS + EXTRA_LINES
) (
    input  logic [NUM_PORTS-1:0]   port_evt,
    input  logic                   phy_evt,
    input  logic                   tsync_evt,
    input  logic [SLEEP_LINES-1:0] sleep_evt,
    output logic [CAP_W-1:0]       set_vec
);
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        if (i == ABSENT_PORT) begin : g_absent
            assign set_vec[i] = 1'b0;
        end else begin : g_present
            assign set_vec[i] = port_evt[i];
        end
    end

    assign set_vec[NUM_PORTS]     = phy_evt;
    assign set_vec[NUM_PORTS + 1] = tsync_evt;

    for (genvar s = 0; s < SLEEP_LINES; s++) begin : g_sleep
        assign set_vec[NUM_PORTS + MISC_LINES + s] = sleep_evt[s];
    end
endmodule

// File: rtl/evt_sticky_reg.sv
module evt_sticky_reg #(
    parameter int unsigned CAP_W       = 13,
    parameter int unsigned ABSENT_PORT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAP_W-1:0] set_vec,
    input  logic [CAP_W-1:0] clr_vec,
    output logic [CAP_W-1:0] cap_q
);
    typedef struct packed {
        logic [CAP_W-1:0] cap;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cap = (st_q.cap & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_q = st_q.cap;

    for (genvar i = 0; i < CAP_W; i++) begin : g_chk
        // R2 R6: a pulse always lands, even against a clearing write
        assert_pulse_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> cap_q[i]);
        // R5: cleared bit without a new pulse drops
        assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !cap_q[i]);
        // R5: a set bit holds while not cleared
        assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_q[i] && !clr_vec[i]) |=> cap_q[i]);
    end

    if (ABSENT_PORT < CAP_W) begin : g_absent_chk
        assert_absent_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cap_q[ABSENT_PORT] == 1'b0);
    end
endmodule

// File: rtl/evt_host_regs.sv
module evt_host_regs
    import evt_capture_pkg::*;
#(
    parameter int unsigned CAP_W  = 13,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [CAP_W-1:0]  cap_q,
    output logic [CAP_W-1:0]  clr_vec,
    output logic              enable_q,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFFSET);
    localparam logic [ADDR_W-1:0] A_CAPT = ADDR_W'(CAPT_OFFSET);

    typedef struct packed {
        logic enable;
    } ctrl_t;

    ctrl_t ct_d, ct_q;

    always_comb begin
        ct_d      = ct_q;
        clr_vec   = '0;
        reg_rdata = '0;
        if (reg_wen && reg_addr == A_CTRL) ct_d.enable = reg_wdata[ENABLE_BIT];
        if (reg_wen && reg_addr == A_CAPT) clr_vec     = reg_wdata[CAP_W-1:0];
        if (reg_addr == A_CTRL) begin
            reg_rdata[ENABLE_BIT] = ct_q.enable;
        end else if (reg_addr == A_CAPT) begin
            reg_rdata[CAP_W-1:0] = cap_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign enable_q = ct_q.enable;

    // R8: reserved capture bits never read back
    assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_CAPT) |-> (reg_rdata[DATA_W-1:CAP_W] == '0));
    // R11: other offsets read as zero
    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != A_CAPT && reg_addr != A_CTRL) |-> (reg_rdata == '0));
    // R9: enable only moves on a control write
    assert_enable_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && reg_addr == A_CTRL) |=> $stable(enable_q));
endmodule

// File: rtl/evt_capture_top.sv
module evt_capture_top
    import evt_capture_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 8,
    parameter int unsigned ABSENT_PORT = 6,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned CAP_W      = NUM_PORTS + EXTRA_LINES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PORTS-1:0]   port_evt,
    input  logic                   phy_evt,
    input  logic                   tsync_evt,
    input  logic [SLEEP_LINES-1:0] sleep_evt,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   reg_wen,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic [CAP_W-1:0]       src_irq,
    output logic                   host_irq
);
    logic [CAP_W-1:0] set_vec;
    logic [CAP_W-1:0] clr_vec;
    logic [CAP_W-1:0] cap_q;
    logic             enable_q;

    evt_pulse_merge #(
        .NUM_PORTS   (NUM_PORTS),
        .ABSENT_PORT (ABSENT_PORT)
    ) u_merge (
        .port_evt  (port_evt),
        .phy_evt   (phy_evt),
        .tsync_evt (tsync_evt),
        .sleep_evt (sleep_evt),
        .set_vec   (set_vec)
    );

    evt_sticky_reg #(
        .CAP_W       (CAP_W),
        .ABSENT_PORT (ABSENT_PORT)
    ) u_sticky (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .cap_q   (cap_q)
    );

    evt_host_regs #(
        .CAP_W  (CAP_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .cap_q     (cap_q),
        .clr_vec   (clr_vec),
        .enable_q  (enable_q),
        .reg_rdata (reg_rdata)
    );

    always_comb begin
        src_irq  = cap_q & {CAP_W{enable_q}};
        host_irq = |src_irq;
    end

    // R9: delivery off silences every line
    assert_gate_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_q |-> (src_irq == '0 && !host_irq));
    // R10: combined line rises only with a pending enabled source
    assert_host_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_irq) |-> (enable_q && cap_q != '0));
endmodule

// File: tb/evt_capture_top_bench.sv
`timescale 1ns/1ps
module evt_capture_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port_evt = '0;
    logic        phy_evt = 1'b0;
    logic        tsync_evt = 1'b0;
    logic [2:0]  sleep_evt = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [12:0] src_irq;
    logic        host_irq;

    int total = 0;
    int bad = 0;

    logic [12:0] m_cap = '0;
    logic        m_en = 1'b0;

    always #2.5 clk = ~clk;

    evt_capture_top u_evt_capture_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_evt  (port_evt),
        .phy_evt   (phy_evt),
        .tsync_evt (tsync_evt),
        .sleep_evt (sleep_evt),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_irq   (src_irq),
        .host_irq  (host_irq)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (a == 8'h40) return {30'd0, m_en, 1'b0};
        if (a == 8'h44) return {19'd0, m_cap};
        return 32'd0;
    endfunction

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] p, input logic ph, input logic ts,
                        input logic [2:0] sl, input logic we, input logic [7:0] a,
                        input logic [31:0] wd, input string tag);
        logic [12:0] ev;
        logic [12:0] exp_irq;
        @(negedge clk);
        exp_irq = m_en ? m_cap : 13'd0;
        check32(tag, "src_irq", {19'd0, src_irq}, {19'd0, exp_irq});
        check32(tag, "host_irq", {31'd0, host_irq}, {31'd0, (exp_irq != 0)});
        port_evt = p; phy_evt = ph; tsync_evt = ts; sleep_evt = sl;
        reg_wen = we; reg_addr = a; reg_wdata = wd;
        #1;
        check32(tag, "reg_rdata", reg_rdata, model_read(a));
        ev = {sl, ts, ph, p};
        ev[6] = 1'b0;
        if (we && a == 8'h44) m_cap = (m_cap & ~wd[12:0]) | ev;
        else                  m_cap = m_cap | ev;
        if (we && a == 8'h40) m_en = wd[1];
    endtask

    task automatic idle(input logic [7:0] a, input string tag);
        step(8'h00, 1'b0, 1'b0, 3'b000, 1'b0, a, 32'h0, tag);
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        idle(8'h44, "R1");
        idle(8'h40, "R1");
        // R2: each present port alone, delivery off
        for (int n = 0; n < 8; n++) begin
            if (n != 6) begin
                step(8'(1 << n), 1'b0, 1'b0, 3'b000, 1'b0, 8'h44, 32'h0, "R2");
                idle(8'h44, "R2");
                step(8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h44, 32'hFFFF_FFFF, "R5");
            end
        end
        // R7: absent port
        step(8'h40, 1'b0, 1'b0, 3'b000, 1'b0, 8'h44, 32'h0, "R7");
        idle(8'h44, "R7");
        step(8'hFF, 1'b0, 1'b0, 3'b000, 1'b0, 8'h44, 32'h0, "R7");
        idle(8'h44, "R7");
        // R3 and R4: other sources
        step(8'h00, 1'b1, 1'b0, 3'b000, 1'b0, 8'h44, 32'h0, "R3");
        step(8'h00, 1'b0, 1'b1, 3'b000, 1'b0, 8'h44, 32'h0, "R3");
        step(8'h00, 1'b0, 1'b0, 3'b001, 1'b0, 8'h44, 32'h0, "R4");
        step(8'h00, 1'b0, 1'b0, 3'b010, 1'b0, 8'h44, 32'h0, "R4");
        step(8'h00, 1'b0, 1'b0, 3'b100, 1'b0, 8'h44, 32'h0, "R4");
        idle(8'h44, "R4");
        // R8: reserved writes ignored, control word readback
        step(8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h44, 32'hFFFF_E000, "R8");
        idle(8'h44, "R8");
        step(8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h40, 32'hFFFF_FFFD, "R8");
        idle(8'h40, "R8");
        // R11: unmapped offsets
        step(8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h48, 32'hFFFF_FFFF, "R11");
        idle(8'h48, "R11");
        idle(8'h00, "R11");
        idle(8'h44, "R11");
        // R9 R10: enable delivery
        step(8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h40, 32'h0000_0002, "R9");
        idle(8'h40, "R9");
        idle(8'h44, "R10");
        // R5: partial clear
        step(8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h44, 32'h0000_0A05, "R5");
        idle(8'h44, "R5");
        // R6: pulse and clear same bit same cycle
        step(8'h08, 1'b0, 1'b0, 3'b000, 1'b1, 8'h44, 32'h0000_0008, "R6");
        idle(8'h44, "R6");
        step(8'h00, 1'b1, 1'b0, 3'b000, 1'b1, 8'h44, 32'hFFFF_FFFF, "R6");
        idle(8'h44, "R6");
        // R9: delivery off while pending
        step(8'h00, 1'b0, 1'b0, 3'b000, 1'b1, 8'h40, 32'h0, "R9");
        idle(8'h44, "R9");
        step(8'h01, 1'b0, 1'b0, 3'b000, 1'b0, 8'h44, 32'h0, "R9");
        idle(8'h44, "R9");
        // R5 R10: random mix
        for (int k = 0; k < 400; k++) begin
            logic [7:0]  rp;
            logic [31:0] r;
            logic [7:0]  ra;
            r  = $urandom;
            rp = 8'($urandom) & 8'($urandom) & 8'($urandom);
            ra = (r[3:2] == 2'd0) ? 8'h40 : ((r[3:2] == 2'd3) ? 8'h4C : 8'h44);
            step(rp, (r[9:6] == 0), (r[13:10] == 0), r[16:14] & r[19:17],
                 (r[23:20] < 3), ra, $urandom, "R10");
        end
        idle(8'h44, "R5");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule